// File: doc/BRIEF.md
# Buffer Pointer and Data Access Port

This block gives a host a narrow window into packet memory through two registers. A pointer register selects a byte address. A data register then reads or writes the byte or the 16-bit word at that address. The host can load the pointer as one 16-bit word. It can also load it as two byte writes: the low byte goes to a staging register, and the whole pointer changes only when the high byte arrives.

Every accepted pointer load starts a prefetch. A small FIFO is filled with the bytes that begin at the new address. The port reports itself busy for a fixed hold interval, about 400 ns at the intended 250 MHz clock. It also stays busy until that FIFO is full. A data read made while the port is busy is answered as not valid and has no effect.

An auto-increment mode, selected by a pin, moves the pointer forward after each data access and refills the FIFO from the new address. With auto-increment off, the pointer must stay even, and odd loads are refused and flagged. Packet memory is held inside the block as two byte-wide synchronous RAM banks, one for even bytes and one for odd bytes.

Top module: `bufptr_port`

## Requirements
- R1: After reset the pointer reads 0, `ptr_odd_err` is 0 and `host_rvalid` is 0.
- R2: A word write (`host_word`=1) at offset 0 or 1 loads the pointer with `host_wdata`. Pointer reads return the whole pointer for a word access, the low byte for a byte access at offset 0, and the high byte for a byte access at offset 1. Byte results appear in bits 7:0 with bits 15:8 zero. Word accesses ignore offset bit 0.
- R3: A byte write at offset 0 only stages `host_wdata[7:0]`, and the pointer keeps its old value. A following byte write at offset 1 loads the pointer with {`host_wdata[7:0]`, staged byte}.
- R4: After each accepted pointer load, `ptr_busy` is high for exactly PREFETCH_CYCLES clock cycles, provided the FIFO has already filled. A data read made while `ptr_busy` is high gets `host_rvalid`=0 and data 0, and leaves the pointer unchanged.
- R5: Reads answer one cycle after the strobe. A byte read at offset 2 returns the byte at the pointer. A byte read at offset 3 returns the byte at pointer+1. A word read at offset 2 or 3 returns {byte at pointer+1, byte at pointer}. An answered data read has `host_rvalid`=1.
- R6: A byte write at offset 2 stores `host_wdata[7:0]` at the pointer. A byte write at offset 3 stores `host_wdata[7:0]` at pointer+1. A word write to offset 2 or 3 stores the low byte at the pointer and the high byte at pointer+1. Later reads return the new contents.
- R7: With `auto_inc_en`=1, each answered data read and each data write advances the pointer by 1 for a byte access and by 2 for a word access. `ptr_busy` is then high until the FIFO has refilled from the new address.
- R8: With `auto_inc_en`=0, data accesses leave the pointer unchanged. An odd pointer load is refused: the pointer is unchanged and `ptr_odd_err` is set. The next accepted load clears `ptr_odd_err`. With `auto_inc_en`=1, odd loads are accepted.
- R9: A pointer load made during a prefetch restarts the full hold interval, and data then comes from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_inc_en | input | 1 | Enables pointer advance after data accesses |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_off | input | 2 | Register offset: 0 pointer low, 1 pointer high, 2 data low, 3 data high |
| host_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| host_rdata | output | 16 | Read data, valid the cycle after `host_rd` |
| host_rvalid | output | 1 | Read answered with valid data |
| ptr_busy | output | 1 | Prefetch hold or FIFO refill in progress |
| ptr_odd_err | output | 1 | Last pointer load was refused for being odd |

## Verification
A wrong pointer shows up on the first pointer read-back. It also shows up on the next data read, which returns bytes from the wrong address. A stale FIFO after a write, or a bad refill after an advance, gives wrong read data in the cycle after the next read strobe. A miscounted hold is caught by sampling `ptr_busy` in the last cycle of the hold and in the cycle after it. A refused odd load that still moved the pointer is seen at once through the error flag and a pointer read.

// File: rtl/bufptr_pkg.sv
// Shared definitions for the buffer pointer / data port.
// Assumes a 16-bit host data path and a 2-bit register offset.
package bufptr_pkg;

    // Register offsets seen by the host
    typedef enum logic [1:0] {
        OFF_PTR_LO  = 2'd0,
        OFF_PTR_HI  = 2'd1,
        OFF_DATA_LO = 2'd2,
        OFF_DATA_HI = 2'd3
    } host_off_e;

    localparam int HOST_W = 16;

endpackage

// File: rtl/bufptr_ram_bank.sv
// One byte-wide synchronous RAM bank, read-first, one port.
// Assumes the caller never needs a read and a write in the same cycle.
module bufptr_ram_bank #(
    parameter int IW = 9
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << IW;

    logic [7:0] mem [DEPTH];

    // Storage access: write when enabled, register the read word
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[idx] <= wdata;
            end
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/bufptr_ptr_reg.sv
// Pointer register with byte staging and odd-value rejection.
// Assumes at most one load or advance request per cycle.
module bufptr_ptr_reg #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_inc_en,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          ld_word,
    input  logic [PW-1:0] wdata,
    input  logic          adv,
    input  logic [PW-1:0] adv_step,
    output logic [PW-1:0] ptr,
    output logic          load_pulse,
    output logic          odd_err
);
    logic [7:0]    stage_q;
    logic [PW-1:0] cand;
    logic          try_load;

    // Candidate value: a full word, or the high byte joined to the staged low byte
    always_comb begin
        cand     = ld_word ? wdata : {wdata[7:0], stage_q};
        try_load = ld_word | ld_hi;
        load_pulse = try_load & (auto_inc_en | ~cand[0]);
    end

    // Staging, pointer update and odd-load flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            ptr     <= '0;
            odd_err <= 1'b0;
        end else begin
            if (ld_lo) begin
                stage_q <= wdata[7:0];
            end
            if (load_pulse) begin
                ptr     <= cand;
                odd_err <= 1'b0;
            end else if (try_load) begin
                odd_err <= 1'b1;
            end else if (adv) begin
                ptr <= ptr + adv_step;
            end
        end
    end
endmodule

// File: rtl/bufptr_prefetch.sv
// Prefetch FIFO: fetches DEPTH consecutive bytes from base, one per cycle.
// Assumes a 1-cycle read latency from the banks; flush drops all entries
// and any read in flight, and fetching restarts from the base of the next cycle.
module bufptr_prefetch #(
    parameter int AW    = 10,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [AW-1:0]     base,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [7:0]        rdata_even,
    input  logic [7:0]        rdata_odd,
    output logic [DEPTH*8-1:0] window,
    output logic              full,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int FW = $clog2(DEPTH+1);
    localparam int EW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [FW-1:0] iss_q;
    logic          pend_q;
    logic [EW-1:0] pend_idx_q;
    logic          pend_bank_q;
    logic [7:0]    ent_q [DEPTH];

    // Issue the next fetch while entries are missing and no flush is pending
    always_comb begin
        rd_en   = ~flush & (iss_q < FW'(DEPTH));
        rd_addr = base + AW'(iss_q);
        full    = (fill == FW'(DEPTH));
    end

    // Fill control: issue count, in-flight tracking and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q       <= '0;
            fill        <= '0;
            pend_q      <= 1'b0;
            pend_idx_q  <= '0;
            pend_bank_q <= 1'b0;
        end else if (flush) begin
            iss_q  <= '0;
            fill   <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q      <= rd_en;
            pend_idx_q  <= EW'(iss_q);
            pend_bank_q <= rd_addr[0];
            if (rd_en) begin
                iss_q <= iss_q + 1'b1;
            end
            if (pend_q) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // Entry capture from the bank that served the fetch in flight
    always_ff @(posedge clk) begin
        if (pend_q && !flush) begin
            ent_q[pend_idx_q] <= pend_bank_q ? rdata_odd : rdata_even;
        end
    end

    // Flatten entries, entry 0 in the low byte
    for (genvar e = 0; e < DEPTH; e++) begin : g_win
        assign window[e*8 +: 8] = ent_q[e];
    end
endmodule

// File: rtl/bufptr_port.sv
// Buffer pointer and data port: host pointer/data registers over packet RAM.
// Assumes one host strobe per cycle (a write wins over a read) and that
// DEPTH >= 2 so that the pointer byte and the byte after it are prefetched.
module bufptr_port
    import bufptr_pkg::*;
#(
    parameter int AW              = 10,
    parameter int DEPTH           = 4,
    parameter int PREFETCH_CYCLES = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        auto_inc_en,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic        host_word,
    input  logic [1:0]  host_off,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_rvalid,
    output logic        ptr_busy,
    output logic        ptr_odd_err
);
    localparam int IW = AW - 1;
    localparam int HW = $clog2(PREFETCH_CYCLES + 1);
    localparam int FW = $clog2(DEPTH + 1);

    logic [HOST_W-1:0] ptr_q;
    logic              load_pulse;
    logic              ld_lo, ld_hi, ld_word;
    logic              wr_data, rd_any, rd_data, adv, flush;
    logic [HOST_W-1:0] step;
    logic [HW-1:0]     hold_q;
    logic              pf_en, pf_full;
    logic [AW-1:0]     pf_addr;
    logic [DEPTH*8-1:0] pf_win;
    logic [FW-1:0]     pf_fill;
    logic [AW-1:0]     wa, wb;
    logic [7:0]        bank_rd [2];
    logic [7:0]        byte0, byte1;

    // Host strobe decode
    always_comb begin
        ld_word = host_wr & host_word & ~host_off[1];
        ld_lo   = host_wr & ~host_word & (host_off == OFF_PTR_LO);
        ld_hi   = host_wr & ~host_word & (host_off == OFF_PTR_HI);
        wr_data = host_wr & host_off[1];
        rd_any  = host_rd & ~host_wr;
        rd_data = rd_any & host_off[1] & ~ptr_busy;
        adv     = auto_inc_en & (wr_data | rd_data);
        step    = host_word ? HOST_W'(2) : HOST_W'(1);
        flush   = load_pulse | adv | wr_data;
        wa      = ptr_q[AW-1:0] + AW'(~host_word & host_off[0]);
        wb      = wa + 1'b1;
        ptr_busy = (hold_q != '0) | ~pf_full;
        byte0   = pf_win[7:0];
        byte1   = pf_win[15:8];
    end

    bufptr_ptr_reg #(.PW(HOST_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_inc_en(auto_inc_en),
        .ld_lo      (ld_lo),
        .ld_hi      (ld_hi),
        .ld_word    (ld_word),
        .wdata      (host_wdata),
        .adv        (adv),
        .adv_step   (step),
        .ptr        (ptr_q),
        .load_pulse (load_pulse),
        .odd_err    (ptr_odd_err)
    );

    // Hold interval after each accepted pointer load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_pulse) begin
            hold_q <= HW'(PREFETCH_CYCLES);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    bufptr_prefetch #(.AW(AW), .DEPTH(DEPTH)) u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .base      (ptr_q[AW-1:0]),
        .rd_en     (pf_en),
        .rd_addr   (pf_addr),
        .rdata_even(bank_rd[0]),
        .rdata_odd (bank_rd[1]),
        .window    (pf_win),
        .full      (pf_full),
        .fill      (pf_fill)
    );

    // Even and odd byte banks; host writes take the port over prefetch reads
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic          we_a, we_b, we, en;
        logic [IW-1:0] idx;
        logic [7:0]    wd;

        always_comb begin
            we_a = wr_data & (wa[0] == 1'(b));
            we_b = wr_data & host_word & (wb[0] == 1'(b));
            we   = we_a | we_b;
            wd   = we_a ? host_wdata[7:0] : host_wdata[15:8];
            idx  = we_a ? wa[AW-1:1] : (we_b ? wb[AW-1:1] : pf_addr[AW-1:1]);
            en   = we | (pf_en & (pf_addr[0] == 1'(b)));
        end

        bufptr_ram_bank #(.IW(IW)) u_bank (
            .clk  (clk),
            .en   (en),
            .we   (we),
            .idx  (idx),
            .wdata(wd),
            .rdata(bank_rd[b])
        );
    end

    // Read response register: pointer or prefetched data, one cycle after strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_any & (~host_off[1] | ~ptr_busy);
            host_rdata  <= '0;
            if (rd_any) begin
                if (!host_off[1]) begin
                    if (host_word)
                        host_rdata <= ptr_q;
                    else if (host_off[0])
                        host_rdata <= {8'h00, ptr_q[15:8]};
                    else
                        host_rdata <= {8'h00, ptr_q[7:0]};
                end else if (!ptr_busy) begin
                    if (host_word)
                        host_rdata <= {byte1, byte0};
                    else if (host_off[0])
                        host_rdata <= {8'h00, byte1};
                    else
                        host_rdata <= {8'h00, byte0};
                end
            end
        end
    end
endmodule

// File: rtl/bufptr_port_chk.sv
// Protocol checker for bufptr_port, attached by bind below.
// Assumes it sees the top-level ports plus the pointer, load pulse and fill level.
module bufptr_port_chk #(
    parameter int DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        auto_inc_en,
    input logic        host_rd,
    input logic        host_wr,
    input logic        host_word,
    input logic [1:0]  host_off,
    input logic        host_rvalid,
    input logic        ptr_busy,
    input logic        ptr_odd_err,
    input logic [15:0] ptr_q,
    input logic        load_pulse,
    input logic [$clog2(DEPTH+1)-1:0] pf_fill
);
    // R4: a load always leaves the port busy in the next cycle
    a_r4_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> ptr_busy);

    // R4: data reads made while busy are not answered as valid
    a_r4_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_off[1] && ptr_busy) |=> !host_rvalid);

    // R5: data reads made while idle are answered
    a_r5_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_off[1] && !ptr_busy) |=> host_rvalid);

    // R3: staging the low byte never moves the pointer
    a_r3_low_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_word && host_off == 2'd0) |=> $stable(ptr_q));

    // R8: a refused odd load leaves the pointer where it was
    a_r8_odd_refused: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptr_odd_err) |-> $stable(ptr_q));

    // R8: without auto-increment, data accesses do not move the pointer
    a_r8_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_inc_en && host_off[1] && (host_rd || host_wr)) |=> $stable(ptr_q));

    // R7: an answered word read advances the pointer by two
    a_r7_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_inc_en && host_rd && !host_wr && host_word && host_off[1] && !ptr_busy)
        |=> ptr_q == $past(ptr_q) + 16'd2);

    // R7: the prefetch FIFO never holds more than its depth
    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pf_fill <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind bufptr_port bufptr_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_inc_en(auto_inc_en),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_word  (host_word),
    .host_off   (host_off),
    .host_rvalid(host_rvalid),
    .ptr_busy   (ptr_busy),
    .ptr_odd_err(ptr_odd_err),
    .ptr_q      (ptr_q),
    .load_pulse (load_pulse),
    .pf_fill    (pf_fill)
);

// File: tb/bufptr_port_test.sv
// Scoreboard bench for bufptr_port: the driver queues expected read answers,
// the monitor pops and compares them one cycle after each read strobe.
module bufptr_port_test;
    localparam int N = 100;  // hold cycles: 400 ns at 4 ns per cycle

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_inc_en = 1'b1;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_word = 1'b0;
    logic [1:0]  host_off = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        ptr_busy;
    logic        ptr_odd_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] d;
        logic        v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;
    logic [7:0] model [1024];
    logic [15:0] p;

    bufptr_port #(.PREFETCH_CYCLES(N)) uut (
        .clk(clk), .rst_n(rst_n), .auto_inc_en(auto_inc_en),
        .host_rd(host_rd), .host_wr(host_wr), .host_word(host_word),
        .host_off(host_off), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .ptr_busy(ptr_busy), .ptr_odd_err(ptr_odd_err)
    );

    always #2 clk = ~clk;  // 250 MHz with 1 ns time units

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: record read strobes at the edge, compare answers half a cycle later
    always @(posedge clk) rd_seen <= host_rd & ~host_wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", host_rdata, 16'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(host_rvalid === e.v && host_rdata === e.d, e.tag,
                      {host_rvalid, host_rdata[14:0]}, {e.v, e.d[14:0]});
                if (host_rdata[15] !== e.d[15])
                    check(1'b0, e.tag, host_rdata, e.d);
            end
        end
    end

    // One strobe cycle, driven between falling edges
    task automatic acc(input bit wr, input bit word, input logic [1:0] off,
                       input logic [15:0] wd);
        @(negedge clk);
        host_wr = wr; host_rd = ~wr; host_word = word;
        host_off = off; host_wdata = wd;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic rd_exp(input bit word, input logic [1:0] off,
                          input logic [15:0] d, input logic v, input string tag);
        exp_t e;
        e.d = d; e.v = v; e.tag = tag;
        exp_q.push_back(e);
        acc(1'b0, word, off, 16'h0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && ptr_busy; i++) @(negedge clk);
        check(!ptr_busy, "port stuck busy", {15'h0, ptr_busy}, 16'h0);
    endtask

    // Word write at offset 2 with auto-increment, mirrored into the model
    task automatic wr_word(input logic [15:0] wd);
        model[p[9:0]] = wd[7:0];
        model[p[9:0] + 10'd1] = wd[15:8];
        acc(1'b1, 1'b1, 2'd2, wd);
        if (auto_inc_en) p = p + 16'd2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 16'h0, 16'h0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ptr_odd_err === 1'b0, "R1 odd flag", {15'h0, ptr_odd_err}, 16'h0);
        check(host_rvalid === 1'b0, "R1 rvalid", {15'h0, host_rvalid}, 16'h0);
        rst_n = 1'b1;
        rd_exp(1'b1, 2'd0, 16'h0000, 1'b1, "R1 pointer after reset");

        // R2: word load and pointer read-back in three widths
        acc(1'b1, 1'b1, 2'd0, 16'h0010);
        p = 16'h0010;
        rd_exp(1'b1, 2'd0, 16'h0010, 1'b1, "R2 word read-back");
        rd_exp(1'b0, 2'd0, 16'h0010, 1'b1, "R2 low byte read-back");
        rd_exp(1'b0, 2'd1, 16'h0000, 1'b1, "R2 high byte read-back");
        wait_idle();

        // R6/R7: fill 0x10..0x1F with words, then byte writes at both offsets
        for (int k = 0; k < 8; k++) wr_word(16'h3100 + 16'(k) * 16'h1213);
        model[10'h020] = 8'h5A;
        acc(1'b1, 1'b0, 2'd2, 16'h005A);   // byte at ptr 0x20, ptr -> 0x21
        model[10'h022] = 8'hC3;
        acc(1'b1, 1'b0, 2'd3, 16'h00C3);   // byte at ptr+1 = 0x22, ptr -> 0x22
        rd_exp(1'b1, 2'd0, 16'h0022, 1'b1, "R7 pointer after word and byte writes");

        // R3: low byte stages only, high byte commits
        acc(1'b1, 1'b0, 2'd0, 16'h0010);
        rd_exp(1'b1, 2'd0, 16'h0022, 1'b1, "R3 pointer unchanged after low byte");
        acc(1'b1, 1'b0, 2'd1, 16'h0000);
        check(ptr_busy === 1'b1, "R4 busy after byte load", {15'h0, ptr_busy}, 16'h1);
        // R4: data read while busy is refused and does not advance
        rd_exp(1'b1, 2'd2, 16'h0000, 1'b0, "R4 read during hold");
        rd_exp(1'b1, 2'd0, 16'h0010, 1'b1, "R3 pointer after high byte");
        wait_idle();

        // R5/R7: reads with auto-increment
        rd_exp(1'b1, 2'd2, {model[10'h11], model[10'h10]}, 1'b1, "R5 word read");
        check(ptr_busy === 1'b1, "R7 refill busy after advance", {15'h0, ptr_busy}, 16'h1);
        wait_idle();
        rd_exp(1'b0, 2'd2, {8'h00, model[10'h12]}, 1'b1, "R5 byte read offset 2");
        wait_idle();
        rd_exp(1'b0, 2'd3, {8'h00, model[10'h14]}, 1'b1, "R5 byte read offset 3");
        wait_idle();
        rd_exp(1'b1, 2'd2, {model[10'h15], model[10'h14]}, 1'b1, "R7 word after byte steps");
        rd_exp(1'b1, 2'd0, 16'h0016, 1'b1, "R7 pointer after reads");

        // R4: exact hold length
        acc(1'b1, 1'b1, 2'd0, 16'h0018);
        repeat (N - 1) @(negedge clk);
        check(ptr_busy === 1'b1, "R4 busy in last hold cycle", {15'h0, ptr_busy}, 16'h1);
        @(negedge clk);
        check(ptr_busy === 1'b0, "R4 idle after hold", {15'h0, ptr_busy}, 16'h0);

        // R9: reload during prefetch restarts the hold and the data
        acc(1'b1, 1'b1, 2'd0, 16'h0010);
        repeat (10) @(negedge clk);
        acc(1'b1, 1'b1, 2'd0, 16'h001C);
        repeat (N - 1) @(negedge clk);
        check(ptr_busy === 1'b1, "R9 hold restarted", {15'h0, ptr_busy}, 16'h1);
        @(negedge clk);
        check(ptr_busy === 1'b0, "R9 hold ends", {15'h0, ptr_busy}, 16'h0);
        rd_exp(1'b1, 2'd2, {model[10'h1D], model[10'h1C]}, 1'b1, "R9 data from new address");

        // R8: odd load refused without auto-increment
        @(negedge clk);
        auto_inc_en = 1'b0;
        acc(1'b1, 1'b1, 2'd0, 16'h0013);
        check(ptr_odd_err === 1'b1, "R8 odd word load flagged", {15'h0, ptr_odd_err}, 16'h1);
        rd_exp(1'b1, 2'd0, 16'h001E, 1'b1, "R8 pointer kept after odd load");
        acc(1'b1, 1'b1, 2'd0, 16'h0014);
        check(ptr_odd_err === 1'b0, "R8 flag cleared by even load", {15'h0, ptr_odd_err}, 16'h0);
        wait_idle();
        rd_exp(1'b1, 2'd2, {model[10'h15], model[10'h14]}, 1'b1, "R8 first read no advance");
        rd_exp(1'b1, 2'd2, {model[10'h15], model[10'h14]}, 1'b1, "R8 repeated read same data");
        rd_exp(1'b0, 2'd3, {8'h00, model[10'h15]}, 1'b1, "R5 byte offset 3 without advance");
        rd_exp(1'b1, 2'd0, 16'h0014, 1'b1, "R8 pointer unchanged by reads");

        // R6: writes without auto-increment refresh the prefetched bytes
        acc(1'b1, 1'b0, 2'd2, 16'h00EE);
        wait_idle();
        rd_exp(1'b1, 2'd2, {model[10'h15], 8'hEE}, 1'b1, "R6 byte write offset 2");
        acc(1'b1, 1'b1, 2'd2, 16'hBEEF);
        wait_idle();
        rd_exp(1'b1, 2'd3, 16'hBEEF, 1'b1, "R6 word write");
        acc(1'b1, 1'b0, 2'd3, 16'h0077);
        wait_idle();
        rd_exp(1'b1, 2'd2, 16'h77EF, 1'b1, "R6 byte write offset 3");

        // R8: odd load by bytes refused, then accepted with auto-increment
        acc(1'b1, 1'b0, 2'd0, 16'h0017);
        acc(1'b1, 1'b0, 2'd1, 16'h0000);
        check(ptr_odd_err === 1'b1, "R8 odd byte load flagged", {15'h0, ptr_odd_err}, 16'h1);
        rd_exp(1'b1, 2'd0, 16'h0014, 1'b1, "R8 pointer kept after odd byte load");
        @(negedge clk);
        auto_inc_en = 1'b1;
        acc(1'b1, 1'b1, 2'd0, 16'h0011);
        check(ptr_odd_err === 1'b0, "R8 odd load accepted in auto mode", {15'h0, ptr_odd_err}, 16'h0);
        wait_idle();
        rd_exp(1'b1, 2'd2, {model[10'h12], model[10'h11]}, 1'b1, "R8 word read at odd pointer");
        rd_exp(1'b1, 2'd0, 16'h0013, 1'b1, "R7 advance from odd pointer");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
        finish_run();
    end
endmodule